// File: doc/BRIEF.md
# Read-Snooping Display Column Latch Decoder

This block watches a processor's external bus: a 16-bit address, active-low read and write strobes and an 8-bit data bus. Its purpose is to let one memory read do two jobs at once. The frame memory answers the read and drives a font byte onto the bus. In the same access, the block recognises that the address aliases onto one display tile's column latch and captures that byte into it. A software loop over the frame addresses therefore refreshes every tile's column data with a single read per tile. No separate write is needed.

The decode ignores address bits 10 down to 8. The low byte selects one of 256 codes, and the top five bits must be zero. Codes below the tile count address column latches and are loaded only by reads. The codes at or above the tile count address the shared row-driver latch, which only a write loads. The system must leave those row addresses unbacked by memory. The bus is sampled on a fast internal clock. A latch takes the last byte seen while its strobe was low, and it loads on the first clock that sees the strobe high again.

Top module: `rd_snoop_col_decoder`

## Requirements
- R1: After reset, every tile byte and the row byte read zero, and `col_load` and `row_load` are low.
- R2: Take a read whose address has bits 15..11 zero and whose low byte n is below 240. At the first clock edge that samples `rd_n` high after it was low, tile n takes the captured byte. In the next cycle `col_load` is 1 for exactly one cycle and `col_code` equals n.
- R3: Address bits 10..8 have no effect on the decode. All eight addresses n, 0x100+n, and so on up to 0x700+n select the same tile n.
- R4: An access with any of address bits 15..11 set changes no latch and raises no load pulse.
- R5: A write never changes a tile byte and never raises `col_load`, whatever its address. `col_load` and `row_load` are never high together.
- R6: Take a write whose address has bits 15..11 zero and a low byte of 240 or more. The row byte takes the captured data at the first edge that samples `wr_n` high again. `row_load` pulses for one cycle, in the same cycle the new row byte appears.
- R7: A read of a row code (low byte 240 or more) leaves the row byte and all tiles unchanged.
- R8: A tile byte holds its value until a later read selects that same tile. A load of one tile leaves every other tile unchanged.
- R9: The byte captured is the data bus value at the last clock edge where the strobe was still low. Values driven earlier in the strobe, or after it rises, are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, faster than the bus strobes |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | Processor address bus |
| bus_data | input | 8 | Processor data bus as driven by memory or CPU |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| tiles_q | output | 1920 | Column latch bytes, tile n in bits 8n+7..8n |
| row_q | output | 8 | Row-driver latch byte |
| col_load | output | 1 | One-cycle pulse after a tile load |
| col_code | output | 8 | Tile index of the most recent tile load |
| row_load | output | 1 | One-cycle pulse after a row load |

## Verification
The bench aims at the decode boundaries. It reads code 239, the last tile, and code 240, the first row code. A design with an off-by-one range compare would load a phantom tile on the row read, or miss the last tile. Every one of the eight aliases of a code is exercised, along with addresses just above 0x07FF. A decoder that wrongly looked at bits 10..8 would scatter the aliases, and one that ignored the top bits would load tiles from far addresses. Writes to column codes and reads of row codes check that each latch answers only its own strobe; swapped strobes would corrupt tiles on writes. Long strobes with a byte change late in the strobe, and bus activity after release, show whether the design captures at the right moment.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_COL  = 2'd1,
    TGT_ROW  = 2'd2
  } tgt_e;

  // True when every address bit at or above first_bit is zero.
  function automatic logic upper_clear(input logic [31:0] a, input int unsigned first_bit);
    return (a >> first_bit) == 32'd0;
  endfunction

  // Classify a select code against the number of tile latches.
  function automatic tgt_e classify(input logic valid, input int unsigned code,
                                    input int unsigned n_tiles);
    if (!valid)             return TGT_NONE;
    else if (code < n_tiles) return TGT_COL;
    else                    return TGT_ROW;
  endfunction

endpackage

// File: rtl/rsd_strobe_track.sv
module rsd_strobe_track (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic release_seen
);
  logic prev_n;

  always_ff @(posedge clk) begin
    if (rst) prev_n <= 1'b1;
    else     prev_n <= strobe_n;
  end

  assign release_seen = !prev_n && strobe_n;
endmodule

// File: rtl/rsd_bus_capture.sv
module rsd_bus_capture #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              any_low,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [ADDR_W-1:0] addr_hold,
  output logic [DATA_W-1:0] data_hold
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_hold <= '0;
      data_hold <= '0;
    end else if (any_low) begin
      addr_hold <= addr_in;
      data_hold <= data_in;
    end
  end
endmodule

// File: rtl/rsd_decoder.sv
module rsd_decoder
  import rsd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned CODE_W    = 8,
  parameter int unsigned SKIP_W    = 3,
  parameter int unsigned NUM_TILES = 240
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [CODE_W-1:0] code,
  output tgt_e              tgt
);
  localparam int unsigned PAGE_LSB = CODE_W + SKIP_W;

  always_comb begin
    hit  = upper_clear(32'(addr), PAGE_LSB);
    code = addr[CODE_W-1:0];
    tgt  = classify(hit, int'(code), NUM_TILES);
  end
endmodule

// File: rtl/rsd_tile_bank.sv
module rsd_tile_bank #(
  parameter int unsigned NUM_TILES = 240,
  parameter int unsigned CODE_W    = 8,
  parameter int unsigned DATA_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          load,
  input  logic [CODE_W-1:0]             code,
  input  logic [DATA_W-1:0]             data,
  output logic [NUM_TILES*DATA_W-1:0]   tiles_q
);
  for (genvar i = 0; i < NUM_TILES; i++) begin : g_tile
    logic sel;
    assign sel = load && (code == CODE_W'(i));
    always_ff @(posedge clk) begin
      if (rst)      tiles_q[i*DATA_W +: DATA_W] <= '0;
      else if (sel) tiles_q[i*DATA_W +: DATA_W] <= data;
    end
  end
endmodule

// File: rtl/rd_snoop_col_decoder.sv
module rd_snoop_col_decoder
  import rsd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CODE_W    = 8,
  parameter int unsigned SKIP_W    = 3,
  parameter int unsigned NUM_TILES = 240
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_data,
  input  logic                        rd_n,
  input  logic                        wr_n,
  output logic [NUM_TILES*DATA_W-1:0] tiles_q,
  output logic [DATA_W-1:0]           row_q,
  output logic                        col_load,
  output logic [CODE_W-1:0]           col_code,
  output logic                        row_load
);
  localparam int unsigned N_STB = 2;
  localparam int unsigned STB_RD = 0;
  localparam int unsigned STB_WR = 1;

  logic [N_STB-1:0] stb_n;
  logic [N_STB-1:0] stb_release;
  assign stb_n = {wr_n, rd_n};

  for (genvar s = 0; s < N_STB; s++) begin : g_stb
    rsd_strobe_track u_trk (
      .clk(clk), .rst(rst), .strobe_n(stb_n[s]), .release_seen(stb_release[s])
    );
  end

  // Named events for the checker
  logic rd_release, wr_release;
  assign rd_release = stb_release[STB_RD];
  assign wr_release = stb_release[STB_WR];

  logic [ADDR_W-1:0] addr_hold;
  logic [DATA_W-1:0] data_hold;

  rsd_bus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .any_low(!(&stb_n)),
    .addr_in(bus_addr), .data_in(bus_data),
    .addr_hold(addr_hold), .data_hold(data_hold)
  );

  logic              dec_hit;
  logic [CODE_W-1:0] dec_code;
  tgt_e              dec_tgt;

  rsd_decoder #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .SKIP_W(SKIP_W),
                .NUM_TILES(NUM_TILES)) u_dec (
    .addr(addr_hold), .hit(dec_hit), .code(dec_code), .tgt(dec_tgt)
  );

  logic tile_wr_en, row_wr_en;
  assign tile_wr_en = rd_release && (dec_tgt == TGT_COL);
  assign row_wr_en  = wr_release && (dec_tgt == TGT_ROW);

  rsd_tile_bank #(.NUM_TILES(NUM_TILES), .CODE_W(CODE_W), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst(rst), .load(tile_wr_en), .code(dec_code),
    .data(data_hold), .tiles_q(tiles_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q    <= '0;
      row_load <= 1'b0;
      col_load <= 1'b0;
      col_code <= '0;
    end else begin
      row_load <= row_wr_en;
      col_load <= tile_wr_en;
      if (row_wr_en)  row_q    <= data_hold;
      if (tile_wr_en) col_code <= dec_code;
    end
  end
endmodule

// File: rtl/rsd_checker.sv
module rsd_checker #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CODE_W    = 8,
  parameter int unsigned NUM_TILES = 240
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        rd_n,
  input logic                        wr_n,
  input logic [NUM_TILES*DATA_W-1:0] tiles_q,
  input logic [DATA_W-1:0]           row_q,
  input logic                        col_load,
  input logic [CODE_W-1:0]           col_code,
  input logic                        row_load,
  input logic                        dec_hit
);
  p_col_needs_read_r2: assert property (@(posedge clk) disable iff (rst)
    col_load |-> ($past(rd_n) && !$past(rd_n, 2)));

  p_col_code_range_r2: assert property (@(posedge clk) disable iff (rst)
    col_load |-> (int'(col_code) < NUM_TILES));

  p_col_page_hit_r4: assert property (@(posedge clk) disable iff (rst)
    col_load |-> $past(dec_hit));

  p_loads_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
    !(col_load && row_load));

  p_row_needs_write_r6: assert property (@(posedge clk) disable iff (rst)
    row_load |-> ($past(wr_n) && !$past(wr_n, 2)));

  p_row_stable_r7: assert property (@(posedge clk) disable iff (rst)
    !row_load |-> $stable(row_q));

  p_tiles_stable_r8: assert property (@(posedge clk) disable iff (rst)
    !col_load |-> $stable(tiles_q));
endmodule

bind rd_snoop_col_decoder rsd_checker #(
  .DATA_W(DATA_W), .CODE_W(CODE_W), .NUM_TILES(NUM_TILES)
) u_chk (
  .clk(clk), .rst(rst), .rd_n(rd_n), .wr_n(wr_n), .tiles_q(tiles_q),
  .row_q(row_q), .col_load(col_load), .col_code(col_code),
  .row_load(row_load), .dec_hit(dec_hit)
);

// File: tb/sim_rd_snoop_col_decoder.sv
module sim_rd_snoop_col_decoder;
  localparam int NT = 240;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic rd_n = 1'b1, wr_n = 1'b1;
  logic [NT*8-1:0] tiles_q;
  logic [7:0] row_q, col_code;
  logic col_load, row_load;

  always #2.5 clk = ~clk;

  rd_snoop_col_decoder u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data(bus_data),
    .rd_n(rd_n), .wr_n(wr_n), .tiles_q(tiles_q), .row_q(row_q),
    .col_load(col_load), .col_code(col_code), .row_load(row_load)
  );

  int checks = 0, errors = 0;
  logic [7:0] m_tile [NT];
  logic [7:0] m_row;

  // 0: none, 1: tile, 2: row
  function automatic int kind_of(input logic [15:0] a);
    if (a >= 16'h0800) return 0;
    return ((a % 256) < NT) ? 1 : 2;
  endfunction

  function automatic int index_of(input logic [15:0] a);
    return int'(a) - 256 * (int'(a) / 256);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req, input bit exp_col, input int exp_idx,
                             input bit exp_row);
    int bad = -1;
    for (int i = 0; i < NT; i++)
      if (bad < 0 && tiles_q[i*8 +: 8] !== m_tile[i]) bad = i;
    if (bad >= 0)
      check(1'b0, req, $sformatf("tile %0d", bad), tiles_q[bad*8 +: 8], m_tile[bad]);
    else check(1'b1, req, "tiles", 0, 0);
    check(row_q === m_row, req, "row_q", row_q, m_row);
    check(col_load === exp_col, req, "col_load", col_load, exp_col);
    check(row_load === exp_row, req, "row_load", row_load, exp_row);
    if (exp_col) check(col_code === 8'(exp_idx), req, "col_code", col_code, exp_idx);
  endtask

  task automatic bus_op(input bit is_rd, input logic [15:0] a, input logic [7:0] d0,
                        input logic [7:0] d1, input int len, input string req);
    int k = kind_of(a);
    @(negedge clk);
    bus_addr = a; bus_data = d0;
    if (is_rd) rd_n = 1'b0; else wr_n = 1'b0;
    repeat (len - 1) @(negedge clk);
    bus_data = d1;
    @(negedge clk);
    rd_n = 1'b1; wr_n = 1'b1;
    bus_data = ~d1;                 // after release: must not be taken (R9)
    @(negedge clk);
    if (is_rd && k == 1) m_tile[index_of(a)] = d1;
    if (!is_rd && k == 2) m_row = d1;
    check_state(req, is_rd && k == 1, index_of(a), !is_rd && k == 2);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2015));
    for (int i = 0; i < NT; i++) m_tile[i] = 8'h00;
    m_row = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_state("R1", 1'b0, 0, 1'b0);

    bus_op(1, 16'h0000, 8'h5A, 8'h5A, 1, "R2");
    bus_op(1, 16'h07EF, 8'hC3, 8'hC3, 1, "R2");           // last tile 239
    for (int j = 0; j < 8; j++)
      bus_op(1, 16'(j * 256 + 17), 8'(j + 8'h30), 8'(j + 8'h30), 1, "R3");
    bus_op(1, 16'h0805, 8'hEE, 8'hEE, 1, "R4");
    bus_op(0, 16'hF8F3, 8'h77, 8'h77, 1, "R4");
    bus_op(1, 16'hFFFF, 8'h11, 8'h11, 2, "R4");
    bus_op(0, 16'h0005, 8'h99, 8'h99, 1, "R5");           // write to tile code
    bus_op(0, 16'h03F0, 8'hA5, 8'hA5, 1, "R6");           // first row code
    bus_op(0, 16'h06FF, 8'h3C, 8'h3C, 2, "R6");
    bus_op(1, 16'h00F0, 8'h01, 8'h01, 1, "R7");           // read row code
    bus_op(1, 16'h0211, 8'h6B, 8'hD4, 4, "R9");           // late data change
    bus_op(0, 16'h04F5, 8'h12, 8'h87, 3, "R9");
    bus_op(1, 16'h0500, 8'h44, 8'h44, 1, "R8");

    for (int n = 0; n < 300; n++) begin
      logic [15:0] a;
      int len;
      a   = (($urandom % 4) != 0) ? 16'($urandom % 16'h0800) : 16'($urandom);
      len = 1 + int'($urandom % 3);
      bus_op(($urandom % 3) != 0, a, 8'($urandom), 8'($urandom), len, "R8");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule